// File: doc/BRIEF.md
# Edge/Level Selectable Interrupt Controller

This block collects up to fifteen interrupt request lines from peripheral blocks and drives a single interrupt output to the host. Software sees four 32-bit words:

| Word | Register | Access |
|------|----------|--------|
| 0 | pending status | read; write-one-to-clear |
| 1 | sensitivity select | read/write |
| 2 | mask | read/write |
| 3 | raw request view | read-only |

In the sensitivity select, each source is set either to latch on a rising edge or to follow its line as a level. In the mask, each source has its own bit, and one extra bit at position 15 gates everything.

Source positions 0 to 14 are fixed: counters 0 to 2, then timers 0 to 2, then serial port, display, analog input, analog output, parallel I/O, internal, and external lines 0 to 2. Bit 15 of the status word summarises whether anything is pending. Writing a one there empties every latched bit at once.

The register port is a simple synchronous write strobe with a word address. The read data is a combinational function of the address. A level-mode request cannot be removed by software. It goes away only when the peripheral drops its line.

Top module: `intc_top`

## Requirements
- R1: After reset, every readable word is zero while all request lines are low, and the interrupt output is low.
- R2: In the sensitivity word (address 1), bit n selects level sensitivity for source n when 0 and edge sensitivity when 1. Bits 15 and above read as 0.
- R3: For an edge-mode source, a request line that is high at a clock edge, after being low at the previous edge, sets its status bit (address 0) from that edge on. The bit stays set after the line falls. The line's history register resets to low, so a line that is high just after reset counts as a rising edge.
- R4: Writing address 0 with a 1 in bit n (n below 15) clears the latched bit of edge-mode source n. Writing 0 in that bit leaves it unchanged.
- R5: For a level-mode source, status bit n equals the live request line. Writes to address 0 do not change it.
- R6: Status bit 15 reads 1 exactly when any of status bits 0 to 14 reads 1.
- R7: Writing address 0 with bit 15 set clears every latched edge-mode bit in the same edge.
- R8: When a rising edge of an edge-mode source coincides with a clear write to its bit, or with a global clear, the bit is set after that edge.
- R9: The interrupt output is 1 exactly when mask bit 15 is 1 and, for some n below 15, both status bit n and mask bit n are 1.
- R10: The raw word (address 3) shows the live request lines in bits 0 to 14 and zero above. Writes to it have no effect.
- R11: The mask word (address 2) stores bits 0 to 15 as written, and bits above 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe for this cycle |
| addr | input | 2 | Word address for reads and writes |
| wrData | input | 32 | Write data |
| reqIn | input | 15 | Peripheral request lines, active high, synchronous to clk |
| rdData | output | 32 | Read data for the word at addr |
| irqOut | output | 1 | Combined interrupt to the host |

## Verification
The assertions take for granted that the request lines are already synchronous to clk and are stable around each rising edge. They also assume that wrEn and addr are never unknown once reset has been released. The bench meets this by changing every input only on the falling edge and by driving known values from time zero. The random phase toggles request lines freely and mixes writes to all four words. This includes clears that land in the same cycle as new edges, and mode changes while bits are pending.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MODE = 2'd1,
    SEL_MASK = 2'd2,
    SEL_RAW  = 2'd3
  } intc_sel_e;

  typedef struct packed {
    logic      statWr;
    logic      clrAll;
    logic      modeWr;
    logic      maskWr;
    intc_sel_e rdSel;
  } intc_strb_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic       glbBit,
  output intc_strb_t strb
);

  always_comb begin
    strb.rdSel  = intc_sel_e'(addr);
    strb.statWr = wrEn && (addr == SEL_STAT);
    strb.modeWr = wrEn && (addr == SEL_MODE);
    strb.maskWr = wrEn && (addr == SEL_MASK);
    strb.clrAll = wrEn && (addr == SEL_STAT) && glbBit;
  end

  // R10: writes to the raw word produce no storage strobe
  a_r10_raw_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd3) |-> !(strb.statWr || strb.modeWr || strb.maskWr));

  a_r7_clear_is_status_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |-> (wrEn && addr == 2'd0));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.statWr, strb.modeWr, strb.maskWr}));

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  intc_strb_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  localparam int GLB = NUM_SRC;

  logic [NUM_SRC-1:0] modeReg, edgePend, reqPrev;
  logic [NUM_SRC-1:0] riseVec, clrVec, statusVec, pendNext;
  logic [GLB:0]       maskReg;
  logic               anyPend;
  logic               unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:GLB+1];

  always_comb begin
    riseVec = reqIn & ~reqPrev;
    if (strb.clrAll)      clrVec = '1;
    else if (strb.statWr) clrVec = wrData[NUM_SRC-1:0];
    else                  clrVec = '0;
    pendNext  = modeReg & (riseVec | (edgePend & ~clrVec));
    statusVec = (modeReg & edgePend) | (~modeReg & reqIn);
    anyPend   = |statusVec;
    irqOut    = maskReg[GLB] && |(statusVec & maskReg[NUM_SRC-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      maskReg  <= '0;
      edgePend <= '0;
      reqPrev  <= '0;
    end else begin
      edgePend <= pendNext;
      reqPrev  <= reqIn;
      if (strb.modeWr) modeReg <= wrData[NUM_SRC-1:0];
      if (strb.maskWr) maskReg <= wrData[GLB:0];
    end
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      SEL_STAT: rdData[GLB:0]       = {anyPend, statusVec};
      SEL_MODE: rdData[NUM_SRC-1:0] = modeReg;
      SEL_MASK: rdData[GLB:0]       = maskReg;
      default:  rdData[NUM_SRC-1:0] = reqIn;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_src
      // R3 and R8: an edge in edge mode always leaves the bit pending
      a_r3_edge_latches: assert property (@(posedge clk) disable iff (!rstN)
        (modeReg[i] && reqIn[i] && !reqPrev[i]) |=> edgePend[i]);
      // R5: level mode never keeps a latched bit
      a_r5_level_no_latch: assert property (@(posedge clk) disable iff (!rstN)
        !modeReg[i] |=> !edgePend[i]);
      // R4: without a clear the latched bit cannot fall
      a_r4_hold_without_clear: assert property (@(posedge clk) disable iff (!rstN)
        (edgePend[i] && modeReg[i] && !clrVec[i]) |=> edgePend[i]);
    end
  endgenerate

  // R7: global clear empties all bits that saw no new edge
  a_r7_global_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> ((edgePend & ~$past(riseVec)) == '0));

  // R9: no interrupt without the global mask bit
  a_r9_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> maskReg[GLB]);

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  intc_strb_t strb;

  intc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .glbBit (wrData[NUM_SRC]),
    .strb   (strb)
  );

  intc_datapath #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .reqIn  (reqIn),
    .rdData (rdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/tb_intc_top.sv
module tb_intc_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic [14:0] reqIn = 15'd0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [14:0] mMode = '0, mPend = '0, mPrev = '0;
  logic [15:0] mMask = '0;

  intc_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .reqIn(reqIn), .rdData(rdData), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] expStatus();
    logic [15:0] s;
    s = '0;
    for (int n = 0; n < 15; n++)
      s[n] = mMode[n] ? mPend[n] : reqIn[n];
    s[15] = (s[14:0] != 0);
    return s;
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0:    return {16'd0, expStatus()};
      2'd1:    return {17'd0, mMode};
      2'd2:    return {16'd0, mMask};
      default: return {17'd0, reqIn};
    endcase
  endfunction

  function automatic logic expIrq();
    logic [15:0] s;
    s = expStatus();
    return mMask[15] && ((s[14:0] & mMask[14:0]) != 0);
  endfunction

  task automatic cyc(input logic [14:0] rq, input logic we, input logic [1:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] er;
    logic        ei;
    logic        clrHit;
    logic        rise;
    @(negedge clk);
    reqIn = rq; wrEn = we; addr = a; wrData = d;
    #2;
    er = expRead(a);
    ei = expIrq();
    checks++;
    if (rdData !== er) begin
      errors++;
      $display("FAIL %s addr=%0d rdData=%h expected=%h", tag, a, rdData, er);
    end
    checks++;
    if (irqOut !== ei) begin
      errors++;
      $display("FAIL %s irqOut=%b expected=%b", tag, irqOut, ei);
    end
    @(posedge clk);
    #1;
    if (!rstN) begin
      mMode = '0; mPend = '0; mPrev = '0; mMask = '0;
    end else begin
      for (int n = 0; n < 15; n++) begin
        rise   = rq[n] && !mPrev[n];
        clrHit = we && (a == 2'd0) && (d[n] || d[15]);
        if (mMode[n]) mPend[n] = rise || (mPend[n] && !clrHit);
        else          mPend[n] = 1'b0;
      end
      if (we && a == 2'd1) mMode = d[14:0];
      if (we && a == 2'd2) mMask = d[15:0];
      mPrev = rq;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state for every word
    for (int a = 0; a < 4; a++) cyc('0, 1'b0, 2'(a), 32'd0, "R1 reset");
    @(negedge clk);
    rstN = 1'b1;
    for (int a = 0; a < 4; a++) cyc('0, 1'b0, 2'(a), 32'd0, "R1 after reset");

    // R2: bits above 14 do not stick
    cyc('0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R2 write mode");
    cyc('0, 1'b0, 2'd1, 32'd0, "R2 readback");
    cyc('0, 1'b1, 2'd1, 32'h0000_00FF, "R2 set mode");
    cyc('0, 1'b0, 2'd1, 32'd0, "R2 readback");

    // R11: mask width
    cyc('0, 1'b1, 2'd2, 32'hFFFF_FFFF, "R11 write mask");
    cyc('0, 1'b0, 2'd2, 32'd0, "R11 readback");

    // R3 and R6: pulse on edge source 2
    cyc(15'h0004, 1'b0, 2'd0, 32'd0, "R3 pulse");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R3 held");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R6 summary");

    // R9: global gate
    cyc(15'h0000, 1'b1, 2'd2, 32'h0000_7FFF, "R9 drop global");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R9 gated");
    cyc(15'h0000, 1'b1, 2'd2, 32'h0000_8000, "R9 only global");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R9 masked source");
    cyc(15'h0000, 1'b1, 2'd2, 32'h0000_FFFF, "R9 restore");

    // R4: write zero keeps, write one clears
    cyc(15'h0000, 1'b1, 2'd0, 32'h0000_0000, "R4 write zero");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R4 still pending");
    cyc(15'h0000, 1'b1, 2'd0, 32'h0000_0004, "R4 clear bit 2");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R4 cleared");

    // R5: level source 9
    cyc(15'h0200, 1'b0, 2'd0, 32'd0, "R5 level high");
    cyc(15'h0200, 1'b1, 2'd0, 32'h0000_8200, "R5 clear ignored");
    cyc(15'h0200, 1'b0, 2'd0, 32'd0, "R5 still high");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R5 follows line");

    // R8: edge on source 3 together with its clear
    cyc(15'h0008, 1'b0, 2'd0, 32'd0, "R8 first edge");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R8 line low");
    cyc(15'h0008, 1'b1, 2'd0, 32'h0000_0008, "R8 edge with clear");
    cyc(15'h0008, 1'b0, 2'd0, 32'd0, "R8 still pending");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R8 line low");
    cyc(15'h0008, 1'b1, 2'd0, 32'h0000_8000, "R8 edge with global clear");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R8 survives global clear");

    // R7: global clear of several bits
    cyc(15'h0013, 1'b0, 2'd0, 32'd0, "R7 set bits");
    cyc(15'h0000, 1'b1, 2'd0, 32'h0000_8000, "R7 global clear");
    cyc(15'h0000, 1'b0, 2'd0, 32'd0, "R7 all cleared");

    // R10: raw view and write ignored
    cyc(15'h5A5A, 1'b0, 2'd3, 32'd0, "R10 raw");
    cyc(15'h25A5, 1'b1, 2'd3, 32'hFFFF_FFFF, "R10 raw write");
    cyc(15'h0000, 1'b0, 2'd3, 32'd0, "R10 raw low");
    cyc(15'h0000, 1'b0, 2'd1, 32'd0, "R10 mode untouched");
    cyc(15'h0000, 1'b0, 2'd2, 32'd0, "R10 mask untouched");

    // Random mix: R3 R4 R5 R6 R7 R8 R9 compared every cycle
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] d;
      logic        we;
      d  = $urandom;
      we = ($urandom % 5) == 0;
      if ((d[31:28] != 4'h0) && we) d[15] = 1'b0;
      cyc(15'($urandom), we, 2'($urandom), d, "R6 R9 random");
    end

    finishRun();
  end

endmodule